// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block collects twelve interrupt sources (four external pins and eight internal peripheral events) into eight vectors and presents at most one request at a time to a CPU. Each request comes with the index of the winning vector and that vector's fixed entry address. Software enables each vector and picks one of two priority levels for it. The controller arbitrates across three levels: low, high and highest. Vectors 0 and 1, which belong to the two main external pins, can be low or highest. Every other vector can be low or high.

Nesting is tracked in hardware by a three-bit in-service record with one bit per level. An acknowledge from the CPU marks the granted level as busy and clears that vector's pending flag. A return strobe frees the most recent (highest) busy level. A new request is only offered when its level is strictly above every level in service. The external pins have selectable triggers: pins 0 and 1 offer edge or level sensing, and pins 2 and 3 offer single or double edge sensing.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `vec_o` holds the index of the granted vector. `addr_o` equals 8*`vec_o`+3, giving 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h and 3Bh for vectors 0 to 7. While `irq_o` is low, `vec_o` is 0 and `addr_o` is 03h.
- R2: Each pin k drives vector k. Peripheral request bits map to vectors as follows: bit0→2, bit1→3, bit2→4, bit3→5, bit4→5, bit5→6, bit6→6, bit7→7. Vectors 2, 3, 5 and 6 therefore each serve two sources.
- R3: The trigger field for pin k is `pin_mode_i[2k+1:2k]`. For pins 0 and 1: 00 selects rising edge, 01 falling edge, 10 high level and 11 low level. For pins 2 and 3: 00 selects rising edge, 01 falling edge, and 10 or 11 both edges.
- R4: An edge or a peripheral pulse sets the vector's pending flag, which holds until that vector is acknowledged. The acknowledge clears the flag for both sources of a shared vector. A new event arriving in the acknowledge cycle keeps the flag set.
- R5: A level-triggered pin requests for exactly as long as the pin is at its active level, and nothing is latched.
- R6: `vec_prio_i[v]`=0 gives vector v low level. `vec_prio_i[v]`=1 gives highest level for vectors 0 and 1, and high level for vectors 2 to 7.
- R7: A request is offered only if its vector is enabled in `vec_en_i` and its level is strictly above the highest in-service level. A disabled vector keeps its pending flag.
- R8: Among eligible requests, the higher level wins. At equal level, the lower vector index wins.
- R9: `ack_i` while `irq_o` is high sets the in-service bit of the granted level (`in_svc_o` bit0 low, bit1 high, bit2 highest). `ack_i` while `irq_o` is low changes nothing.
- R10: `reti_i` clears the highest set in-service bit. When `reti_i` and `ack_i` are both high, only the return takes effect and the acknowledge is ignored.
- R11: After reset, `irq_o` is low, `in_svc_o` is 000 and no vector is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | External interrupt pin levels, synchronous to clk_i |
| pin_mode_i | input | 8 | Two-bit trigger select per pin |
| periph_req_i | input | 8 | One-cycle peripheral event pulses |
| vec_en_i | input | 8 | Per-vector enable |
| vec_prio_i | input | 8 | Per-vector priority select |
| ack_i | input | 1 | CPU acknowledge of the offered vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Request to the CPU |
| vec_o | output | 3 | Granted vector index |
| addr_o | output | 8 | Entry address of granted vector |
| in_svc_o | output | 3 | In-service bit per level |

## Verification
The bench goes after the nesting edge cases:
- An equal-level request while that level is in service must stay blocked. A design using a greater-or-equal compare would re-enter the running handler.
- An acknowledge and a return in the same cycle must leave the stack empty with the request still pending. A design that applied both would lose a level or drop the request.
- An event landing in the acknowledge cycle must survive, or a second occurrence of a shared source would vanish.
- Level-sensed pins must drop the request when the pin returns to its idle level, and double-edge pins must fire on the falling edge too.
- Arbitration ties must resolve towards the lower index.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_VEC     = 8;
  localparam int NUM_PIN     = 4;
  localparam int NUM_PERIPH  = 8;
  localparam int NUM_LVL     = 3;
  localparam int NUM_TOP_VEC = 2;
  localparam int VEC_W       = $clog2(NUM_VEC);
  localparam int LVL_W       = $clog2(NUM_LVL + 1);

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_NONE = lvl_t'(0);
  localparam lvl_t LVL_LOW  = lvl_t'(1);
  localparam lvl_t LVL_HIGH = lvl_t'(2);
  localparam lvl_t LVL_TOP  = lvl_t'(3);

  // vector served by each peripheral request bit
  function automatic int periph_vec(input int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3, 4:    return 5;
      5, 6:    return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  output logic       edge_o,
  output logic       level_o
);
  logic pin_q, pin_d;
  logic rise, fall;

  assign pin_d = pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;

  always_comb begin
    edge_o  = 1'b0;
    level_o = 1'b0;
    case (mode_i)
      2'b00: edge_o = rise;
      2'b01: edge_o = fall;
      2'b10: begin
        if (LEVEL_OK) level_o = pin_i;
        else          edge_o  = rise | fall;
      end
      default: begin
        if (LEVEL_OK) level_o = ~pin_i;
        else          edge_o  = rise | fall;
      end
    endcase
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NUM_VEC-1:0]       req_i,
  input  logic [NUM_VEC-1:0]       en_i,
  input  lvl_t [NUM_VEC-1:0]       lvl_i,
  input  lvl_t                     cur_lvl_i,
  output logic                     vld_o,
  output logic [VEC_W-1:0]         vec_o,
  output lvl_t                     lvl_o
);
  // ascending scan with strict compare: ties keep the lower index
  always_comb begin
    vld_o = 1'b0;
    vec_o = '0;
    lvl_o = LVL_NONE;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (req_i[v] && en_i[v] && (lvl_i[v] > cur_lvl_i) && (lvl_i[v] > lvl_o)) begin
        vld_o = 1'b1;
        vec_o = VEC_W'(v);
        lvl_o = lvl_i[v];
      end
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  lvl_t               set_lvl_i,
  input  logic               clr_i,
  output logic [NUM_LVL-1:0] svc_o,
  output lvl_t               cur_lvl_o
);
  logic [NUM_LVL-1:0] svc_q, svc_d;
  logic               svc_en;

  always_comb begin
    logic done;
    done  = 1'b0;
    svc_d = svc_q;
    if (clr_i) begin
      for (int b = NUM_LVL - 1; b >= 0; b--) begin
        if (svc_q[b] && !done) begin
          svc_d[b] = 1'b0;
          done     = 1'b1;
        end
      end
    end else if (set_i && (set_lvl_i != LVL_NONE)) begin
      svc_d[int'(set_lvl_i) - 1] = 1'b1;
    end
  end

  assign svc_en = clr_i | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     svc_q <= '0;
    else if (svc_en) svc_q <= svc_d;
  end

  always_comb begin
    cur_lvl_o = LVL_NONE;
    for (int b = 0; b < NUM_LVL; b++) begin
      if (svc_q[b]) cur_lvl_o = lvl_t'(b + 1);
    end
  end

  assign svc_o = svc_q;

  // R9
  ack_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> (svc_q > $past(svc_q)));

  // R10
  ret_pops_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (svc_q != '0)) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_PIN-1:0]      pin_i,
  input  logic [2*NUM_PIN-1:0]    pin_mode_i,
  input  logic [NUM_PERIPH-1:0]   periph_req_i,
  input  logic [NUM_VEC-1:0]      vec_en_i,
  input  logic [NUM_VEC-1:0]      vec_prio_i,
  input  logic                    ack_i,
  input  logic                    reti_i,
  output logic                    irq_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [NUM_LVL-1:0]      in_svc_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // pin trigger decode
  logic [NUM_PIN-1:0] pin_edge, pin_level;

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    irq_pin_detect #(
      .LEVEL_OK (p < NUM_TOP_VEC)
    ) u_pin (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .pin_i   (pin_i[p]),
      .mode_i  (pin_mode_i[2*p +: 2]),
      .edge_o  (pin_edge[p]),
      .level_o (pin_level[p])
    );
  end

  // source to vector fold
  logic [NUM_VEC-1:0] hit_vec, lvl_req;

  always_comb begin
    hit_vec = '0;
    lvl_req = '0;
    for (int p = 0; p < NUM_PIN; p++) begin
      hit_vec[p] = hit_vec[p] | pin_edge[p];
      lvl_req[p] = lvl_req[p] | pin_level[p];
    end
    for (int i = 0; i < NUM_PERIPH; i++) begin
      hit_vec[periph_vec(i)] = hit_vec[periph_vec(i)] | periph_req_i[i];
    end
  end

  // level per vector
  lvl_t [NUM_VEC-1:0] vec_lvl;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_lvl
    if (v < NUM_TOP_VEC) begin : g_top
      assign vec_lvl[v] = vec_prio_i[v] ? LVL_TOP : LVL_LOW;
    end else begin : g_std
      assign vec_lvl[v] = vec_prio_i[v] ? LVL_HIGH : LVL_LOW;
    end
  end

  // pending flags, grant, acknowledge
  logic [NUM_VEC-1:0] pend_q, pend_d, clr_mask, req_vec;
  logic               grant_vld, ack_fire;
  logic [VEC_W-1:0]   grant_vec;
  lvl_t               grant_lvl, cur_lvl;

  assign req_vec  = pend_q | lvl_req;
  assign ack_fire = ack_i & grant_vld & ~reti_i;

  always_comb begin
    clr_mask = '0;
    if (ack_fire) clr_mask[grant_vec] = 1'b1;
    pend_d = (pend_q & ~clr_mask) | hit_vec;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  irq_arbiter u_arb (
    .req_i     (req_vec),
    .en_i      (vec_en_i),
    .lvl_i     (vec_lvl),
    .cur_lvl_i (cur_lvl),
    .vld_o     (grant_vld),
    .vec_o     (grant_vec),
    .lvl_o     (grant_lvl)
  );

  irq_svc_stack u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .set_i     (ack_fire),
    .set_lvl_i (grant_lvl),
    .clr_i     (reti_i),
    .svc_o     (in_svc_o),
    .cur_lvl_o (cur_lvl)
  );

  assign irq_o  = grant_vld;
  assign vec_o  = grant_vec;
  assign addr_o = ADDR_W'(VEC_BASE + VEC_STRIDE * int'(grant_vec));

  // R7
  en_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> vec_en_i[vec_o]);

  // R7
  above_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (grant_lvl > cur_lvl));

  // R6
  top_only_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o && (grant_lvl == LVL_TOP)) |-> (grant_vec < VEC_W'(NUM_TOP_VEC)));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_pend_chk
    // R4
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      $fell(pend_q[v]) |-> $past(ack_fire && (grant_vec == VEC_W'(v))));
  end
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [3:0] pin_i;
  logic [7:0] pin_mode_i, periph_req_i, vec_en_i, vec_prio_i;
  logic       ack_i, reti_i;
  logic       irq_o;
  logic [2:0] vec_o;
  logic [7:0] addr_o;
  logic [2:0] in_svc_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin_i), .pin_mode_i(pin_mode_i),
    .periph_req_i(periph_req_i), .vec_en_i(vec_en_i), .vec_prio_i(vec_prio_i),
    .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o), .vec_o(vec_o),
    .addr_o(addr_o), .in_svc_o(in_svc_o)
  );

  // {pulse[27:20], enable[19:12], prio[11:4], irq[3], vec[2:0]}
  localparam logic [27:0] TAB [11] = '{
    {8'h01, 8'hFF, 8'h00, 1'b1, 3'd2},
    {8'h80, 8'hFF, 8'h00, 1'b1, 3'd7},
    {8'h82, 8'hFF, 8'h80, 1'b1, 3'd7},
    {8'h82, 8'hFF, 8'h00, 1'b1, 3'd3},
    {8'h10, 8'hFF, 8'h00, 1'b1, 3'd5},
    {8'h40, 8'hFF, 8'h00, 1'b1, 3'd6},
    {8'h04, 8'hEF, 8'h00, 1'b0, 3'd0},
    {8'h24, 8'hFF, 8'h40, 1'b1, 3'd6},
    {8'hFF, 8'hFF, 8'h00, 1'b1, 3'd2},
    {8'hFF, 8'hFF, 8'h30, 1'b1, 3'd4},
    {8'h00, 8'hFF, 8'hFF, 1'b0, 3'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; pin_i = '0; pin_mode_i = '0; periph_req_i = '0;
    vec_en_i = '0; vec_prio_i = '0; ack_i = 1'b0; reti_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] m);
    periph_req_i = m;
    @(negedge clk);
    periph_req_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic reti();
    reti_i = 1'b1;
    @(negedge clk);
    reti_i = 1'b0;
  endtask

  task automatic set_pin(input int k, input logic val);
    pin_i[k] = val;
    @(negedge clk);
  endtask

  task automatic chk_grant(input string tag, input logic exp_irq, input logic [2:0] exp_vec);
    check(tag, {31'd0, irq_o}, {31'd0, exp_irq});
    check(tag, {29'd0, vec_o}, {29'd0, exp_vec});
    check(tag, {24'd0, addr_o}, {24'd0, 8'(exp_vec * 8 + 3)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    do_reset();
    check("R11 irq", {31'd0, irq_o}, 32'd0);
    check("R11 svc", {29'd0, in_svc_o}, 32'd0);
    check("R1 idle vec", {29'd0, vec_o}, 32'd0);

    // R2 R7 R8 table walk
    for (int i = 0; i < 11; i++) begin
      do_reset();
      vec_en_i   = TAB[i][19:12];
      vec_prio_i = TAB[i][11:4];
      pulse(TAB[i][27:20]);
      chk_grant($sformatf("R2 R7 R8 entry %0d", i), TAB[i][3], TAB[i][2:0]);
    end

    // R3 R4 rising edge on pin 0 latches past the pulse
    do_reset();
    vec_en_i = 8'h01;
    set_pin(0, 1'b1);
    set_pin(0, 1'b0);
    chk_grant("R4 pin0 latched", 1'b1, 3'd0);
    ack();
    check("R9 svc low", {29'd0, in_svc_o}, 32'd1);
    check("R4 cleared irq", {31'd0, irq_o}, 32'd0);
    reti();
    check("R10 svc empty", {29'd0, in_svc_o}, 32'd0);
    check("R4 no repeat", {31'd0, irq_o}, 32'd0);

    // R5 level mode on pin 1, highest level
    do_reset();
    pin_mode_i = 8'b0000_1000;
    vec_en_i   = 8'h02;
    vec_prio_i = 8'h02;
    set_pin(1, 1'b1);
    chk_grant("R5 level high", 1'b1, 3'd1);
    ack();
    check("R6 svc highest", {29'd0, in_svc_o}, 32'd4);
    reti();
    chk_grant("R5 level persists", 1'b1, 3'd1);
    set_pin(1, 1'b0);
    check("R5 level dropped", {31'd0, irq_o}, 32'd0);
    pin_mode_i = 8'b0000_1100;
    @(negedge clk);
    chk_grant("R3 low level", 1'b1, 3'd1);

    // R7 R9 nesting
    do_reset();
    vec_en_i   = 8'hFF;
    vec_prio_i = 8'h08;
    pulse(8'h01);
    ack();
    pulse(8'h02);
    chk_grant("R7 high over low", 1'b1, 3'd3);
    ack();
    check("R9 svc two", {29'd0, in_svc_o}, 32'd3);
    pulse(8'h80);
    check("R7 low blocked", {31'd0, irq_o}, 32'd0);
    ack();
    check("R9 idle ack", {29'd0, in_svc_o}, 32'd3);
    reti();
    check("R10 pop high", {29'd0, in_svc_o}, 32'd1);
    check("R7 equal blocked", {31'd0, irq_o}, 32'd0);
    reti();
    chk_grant("R7 resumes", 1'b1, 3'd7);

    // R6 highest preempts high
    do_reset();
    vec_en_i   = 8'hFF;
    vec_prio_i = 8'h09;
    pulse(8'h02);
    ack();
    check("R6 svc high", {29'd0, in_svc_o}, 32'd2);
    set_pin(0, 1'b1);
    chk_grant("R6 top preempts", 1'b1, 3'd0);
    ack();
    check("R6 svc stack", {29'd0, in_svc_o}, 32'd6);

    // R10 ack and return together
    do_reset();
    vec_en_i   = 8'hFF;
    vec_prio_i = 8'h08;
    pulse(8'h01);
    ack();
    pulse(8'h02);
    ack_i = 1'b1; reti_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0; reti_i = 1'b0;
    check("R10 both svc", {29'd0, in_svc_o}, 32'd0);
    chk_grant("R10 ack ignored", 1'b1, 3'd3);

    // R4 event in acknowledge cycle survives
    do_reset();
    vec_en_i = 8'hFF;
    pulse(8'h01);
    ack_i = 1'b1; periph_req_i = 8'h01;
    @(negedge clk);
    ack_i = 1'b0; periph_req_i = '0;
    check("R4 ack svc", {29'd0, in_svc_o}, 32'd1);
    check("R4 blocked", {31'd0, irq_o}, 32'd0);
    reti();
    chk_grant("R4 kept event", 1'b1, 3'd2);

    // R3 both edges on pin 2, falling on pin 3
    do_reset();
    pin_mode_i = 8'b0110_0000;
    vec_en_i   = 8'hFF;
    set_pin(2, 1'b1);
    chk_grant("R3 pin2 rise", 1'b1, 3'd2);
    ack(); reti();
    set_pin(2, 1'b0);
    chk_grant("R3 pin2 fall", 1'b1, 3'd2);
    ack(); reti();
    check("R3 pin2 quiet", {31'd0, irq_o}, 32'd0);
    set_pin(3, 1'b1);
    check("R3 pin3 rise ignored", {31'd0, irq_o}, 32'd0);
    set_pin(3, 1'b0);
    chk_grant("R3 pin3 fall", 1'b1, 3'd3);

    // R7 disabled vector keeps pending, R1 last address
    do_reset();
    pulse(8'h80);
    check("R7 masked", {31'd0, irq_o}, 32'd0);
    vec_en_i = 8'h80;
    @(negedge clk);
    chk_grant("R1 R7 unmasked", 1'b1, 3'd7);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule